// File: doc/BRIEF.md
# Floating-Point Exception Mask and Response Unit

This unit sits at the output of a floating-point arithmetic datapath. The datapath hands it a finished operation, which is a 64-bit double-precision result, the sign implied by the operand signs, and a vector of six raw exception conditions. A 16-bit control word that software can write decides what happens to each condition.

When every raised condition is masked, the operation commits. Invalid, divide-by-zero and overflow replace the result with a fixed default value. Denormal operand, underflow and precision let the datapath's own result through, because that result is already the denormalized or rounded value. When any raised condition is unmasked, nothing commits. Instead a pending-trap latch is set, and the trap is reported to the core only when the next floating-point instruction issues.

The unit also holds one sticky status flag per exception class. It drives the precision-control, rounding-control and infinity-control fields of the control word to the datapath.

Top module: `fpx_resp_unit`

## Requirements
- R1: After reset the control word reads 0x003F, so all six mask bits are set and every other bit is 0. The status flags read 0, `res_valid_o` is 0, and `trap_o` stays 0 even while `issue_i` is high.
- R2: A write (`cw_we_i`) shows on `cw_rdata_o` in the next cycle with all 16 bits as written. An operation presented in the same cycle as the write is still handled with the old masks.
- R3: Three fields of the control word go to the datapath unchanged: `prec_ctl_o` is bits 9:8, `rnd_ctl_o` is bits 11:10 and `inf_ctl_o` is bit 12.
- R4: The exception vector and the mask bits share one bit order: 0 invalid, 1 denormal operand, 2 divide-by-zero, 3 overflow, 4 underflow, 5 precision. A masked invalid operation commits 0x7FF8000000000000 one cycle after `op_valid_i`.
- R5: A masked divide-by-zero commits an infinity: `op_sign_i`, then an exponent of all ones, then a zero fraction.
- R6: A masked overflow commits the largest finite magnitude carrying `op_sign_i`: exponent 0x7FE and a fraction of all ones.
- R7: When the only raised conditions are masked denormal operand, underflow or precision, or when no condition is raised, `op_result_i` commits unchanged.
- R8: When several masked conditions are raised together, the default is chosen in the order invalid, then divide-by-zero, then overflow.
- R9: If any raised condition is unmasked, `res_valid_o` stays 0 for that operation and a trap becomes pending.
- R10: `trap_o` is high in any cycle in which `issue_i` is high and a trap is pending. The trap must come from an operation presented in an earlier cycle. It stays pending across issues until it is cleared.
- R11: Each status flag sets when its condition arrives with `op_valid_i`, whether or not it is masked. A flag holds until it is cleared.
- R12: `clr_i` clears all status flags and the pending trap at the next edge. An operation presented in the same cycle as the clear is still recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cw_we_i | input | 1 | Control word write strobe |
| cw_wdata_i | input | 16 | Control word write data |
| cw_rdata_o | output | 16 | Current control word |
| prec_ctl_o | output | 2 | Precision-control field |
| rnd_ctl_o | output | 2 | Rounding-control field |
| inf_ctl_o | output | 1 | Infinity-control bit |
| op_valid_i | input | 1 | Operation finished this cycle |
| op_exc_i | input | 6 | Raw exception conditions of the operation |
| op_sign_i | input | 1 | Sign for a default infinity or maximum value |
| op_result_i | input | 64 | Result computed by the datapath |
| res_valid_o | output | 1 | Result commits (registered) |
| res_o | output | 64 | Committed result (registered) |
| sts_o | output | 6 | Sticky exception flags |
| issue_i | input | 1 | Next floating-point instruction issues |
| clr_i | input | 1 | Clear status flags and pending trap |
| trap_o | output | 1 | Deferred trap reported at issue |

## Verification
The hardest case to reach from the ports is a deferred trap meeting other events. An unmasked condition latched in one cycle must be reported only at a later issue. That issue may coincide with a new operation, a clear, or a control word write that changes the masks in the same cycle. Directed sequences cover each of these cases: an issue in the same cycle as the faulting operation, repeated issues, and a clear together with an issue. Seeded random cycles then put partial masks, sparse multi-bit exception vectors, writes, clears and issues on top of each other. A bench-side model predicts every output.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int unsigned CW_W   = 16;
  localparam int unsigned N_EXC  = 6;
  localparam int unsigned RES_W  = 64;
  localparam int unsigned EXP_W  = 11;
  localparam int unsigned FRAC_W = RES_W - EXP_W - 1;

  // exception / mask bit positions
  localparam int unsigned X_INV = 0;
  localparam int unsigned X_DEN = 1;
  localparam int unsigned X_DZ  = 2;
  localparam int unsigned X_OVF = 3;
  localparam int unsigned X_UNF = 4;
  localparam int unsigned X_PRE = 5;

  localparam int unsigned PC_LO  = 8;
  localparam int unsigned RC_LO  = 10;
  localparam int unsigned IC_BIT = 12;

  localparam logic [CW_W-1:0]  CW_RST = CW_W'(16'h003F);
  localparam logic [RES_W-1:0] QNAN   = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
endpackage

// File: rtl/fpx_ctl_word.sv
module fpx_ctl_word
  import fpx_pkg::*;
#(
  parameter int unsigned W = CW_W,
  parameter logic [W-1:0] RST_VAL = CW_RST
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cw_o
);
  logic [W-1:0] cw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cw_q <= RST_VAL;
    else if (we_i) cw_q <= wdata_i;
  end

  assign cw_o = cw_q;

  p_cw_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> cw_q == $past(wdata_i));
endmodule

// File: rtl/fpx_subst.sv
module fpx_subst
  import fpx_pkg::*;
(
  input  logic             inv_i,
  input  logic             dz_i,
  input  logic             ovf_i,
  input  logic             sign_i,
  input  logic [RES_W-1:0] res_i,
  output logic [RES_W-1:0] res_o
);
  localparam logic [RES_W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [RES_W-2:0] MAX_MAG = {{(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};

  // fixed priority: invalid > divide-by-zero > overflow
  always_comb begin
    if (inv_i)      res_o = QNAN;
    else if (dz_i)  res_o = {sign_i, INF_MAG};
    else if (ovf_i) res_o = {sign_i, MAX_MAG};
    else            res_o = res_i;
  end
endmodule

// File: rtl/fpx_flags.sv
module fpx_flags #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         rec_i,
  input  logic [N-1:0] exc_i,
  input  logic         trap_req_i,
  output logic [N-1:0] flags_o,
  output logic         pend_o
);
  logic [N-1:0] flags_q;
  logic         pend_q;

  for (genvar g = 0; g < N; g++) begin : g_flag
    // a new event wins over a clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 flags_q[g] <= 1'b0;
      else if (rec_i && exc_i[g])  flags_q[g] <= 1'b1;
      else if (clr_i)              flags_q[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pend_q <= 1'b0;
    else if (trap_req_i) pend_q <= 1'b1;
    else if (clr_i)      pend_q <= 1'b0;
  end

  assign flags_o = flags_q;
  assign pend_o  = pend_q;

  p_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (flags_q & $past(flags_q)) == $past(flags_q));
  p_flag_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_i |=> (flags_q & $past(exc_i)) == $past(exc_i));
  p_flag_clr_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !rec_i |=> flags_q == '0);
  p_pend_clr_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !trap_req_i |=> !pend_q);
endmodule

// File: rtl/fpx_resp_unit.sv
module fpx_resp_unit
  import fpx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cw_we_i,
  input  logic [CW_W-1:0]  cw_wdata_i,
  output logic [CW_W-1:0]  cw_rdata_o,
  output logic [1:0]       prec_ctl_o,
  output logic [1:0]       rnd_ctl_o,
  output logic             inf_ctl_o,
  input  logic             op_valid_i,
  input  logic [N_EXC-1:0] op_exc_i,
  input  logic             op_sign_i,
  input  logic [RES_W-1:0] op_result_i,
  output logic             res_valid_o,
  output logic [RES_W-1:0] res_o,
  output logic [N_EXC-1:0] sts_o,
  input  logic             issue_i,
  input  logic             clr_i,
  output logic             trap_o
);
  logic [CW_W-1:0]  cw;
  logic [N_EXC-1:0] mask, unmasked;
  logic             trap_req, commit, pend;
  logic [RES_W-1:0] subst_res, res_q;
  logic             vld_q;

  fpx_ctl_word #(.W(CW_W), .RST_VAL(CW_RST)) i_cw (
    .clk_i, .rst_ni, .we_i(cw_we_i), .wdata_i(cw_wdata_i), .cw_o(cw)
  );

  assign mask     = cw[N_EXC-1:0];
  assign unmasked = op_exc_i & ~mask;
  assign trap_req = op_valid_i && (|unmasked);
  assign commit   = op_valid_i && !(|unmasked);

  fpx_subst i_subst (
    .inv_i(op_exc_i[X_INV]), .dz_i(op_exc_i[X_DZ]), .ovf_i(op_exc_i[X_OVF]),
    .sign_i(op_sign_i), .res_i(op_result_i), .res_o(subst_res)
  );

  fpx_flags #(.N(N_EXC)) i_flags (
    .clk_i, .rst_ni, .clr_i, .rec_i(op_valid_i), .exc_i(op_exc_i),
    .trap_req_i(trap_req), .flags_o(sts_o), .pend_o(pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= commit;
      if (commit) res_q <= subst_res;
    end
  end

  assign res_valid_o = vld_q;
  assign res_o       = res_q;
  assign trap_o      = issue_i && pend;
  assign cw_rdata_o  = cw;
  assign prec_ctl_o  = cw[PC_LO+1:PC_LO];
  assign rnd_ctl_o   = cw[RC_LO+1:RC_LO];
  assign inf_ctl_o   = cw[IC_BIT];

  p_dflt_qnan_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op_exc_i[X_INV] && (op_exc_i & ~cw[N_EXC-1:0]) == '0
    |=> res_valid_o && res_o == QNAN);
  p_no_commit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && (op_exc_i & ~cw[N_EXC-1:0]) != '0 |=> !res_valid_o && pend);
  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> !res_valid_o);
endmodule

// File: tb/test_fpx_resp_unit.sv
module test_fpx_resp_unit;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, cw_we, op_valid, op_sign, issue, clr;
  logic [15:0] cw_wdata, cw_rdata;
  logic [1:0]  prec_ctl, rnd_ctl;
  logic        inf_ctl, res_valid, trap;
  logic [5:0]  op_exc, sts;
  logic [63:0] op_result, res;

  fpx_resp_unit i_fpx_resp_unit (
    .clk_i(clk), .rst_ni(rst_n), .cw_we_i(cw_we), .cw_wdata_i(cw_wdata),
    .cw_rdata_o(cw_rdata), .prec_ctl_o(prec_ctl), .rnd_ctl_o(rnd_ctl),
    .inf_ctl_o(inf_ctl), .op_valid_i(op_valid), .op_exc_i(op_exc),
    .op_sign_i(op_sign), .op_result_i(op_result), .res_valid_o(res_valid),
    .res_o(res), .sts_o(sts), .issue_i(issue), .clr_i(clr), .trap_o(trap)
  );

  int total = 0, bad = 0, ncyc = 0;
  bit finished = 0;
  logic [15:0] cw_m;
  logic [5:0]  flg_m;
  logic        pend_m;

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 20000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=%0d exp<=20000 cycles", ncyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_res(logic [5:0] e, logic s, logic [63:0] r);
    if (e[0])      return 64'h7FF8_0000_0000_0000;
    else if (e[2]) return {s, 63'h7FF0_0000_0000_0000};
    else if (e[3]) return {s, 63'h7FEF_FFFF_FFFF_FFFF};
    else           return r;
  endfunction

  task automatic cyc(logic we, logic [15:0] wd, logic ov, logic [5:0] e,
                     logic s, logic [63:0] r, logic iss, logic cl);
    logic [5:0]  unm;
    logic        ev;
    logic [63:0] er;
    @(negedge clk);
    cw_we = we; cw_wdata = wd; op_valid = ov; op_exc = e;
    op_sign = s; op_result = r; issue = iss; clr = cl;
    #1;
    chk("R10 trap at issue", 64'(trap), 64'(iss & pend_m));
    unm = e & ~cw_m[5:0];
    ev  = ov && (unm == 6'd0);
    er  = exp_res(e, s, r);
    if (cl) begin flg_m = '0; pend_m = 1'b0; end
    if (ov) begin
      flg_m = flg_m | e;
      if (unm != 6'd0) pend_m = 1'b1;
    end
    if (we) cw_m = wd;
    @(posedge clk); #1;
    chk("R9 res_valid", 64'(res_valid), 64'(ev));
    if (ev) chk("R4/R5/R6/R7/R8 committed result", res, er);
    chk("R11/R12 flags", 64'(sts), 64'(flg_m));
    chk("R2 cw readback", 64'(cw_rdata), 64'(cw_m));
    chk("R3 exported fields", 64'({inf_ctl, rnd_ctl, prec_ctl}), 64'(cw_m[12:8]));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cw_we = 0; cw_wdata = '0; op_valid = 0; op_exc = '0;
    op_sign = 0; op_result = '0; issue = 1'b1; clr = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 cw reset", 64'(cw_rdata), 64'h003F);
    chk("R1 flags reset", 64'(sts), 64'h0);
    chk("R1 res_valid reset", 64'(res_valid), 64'h0);
    chk("R1 no trap", 64'(trap), 64'h0);
    cw_m = 16'h003F; flg_m = '0; pend_m = 1'b0;
    @(negedge clk); rst_n = 1'b1; issue = 1'b0;

    cyc(0, 0, 1, 6'h01, 1, 64'h1234, 0, 0);                 // R4
    cyc(0, 0, 1, 6'h04, 1, 64'h1234, 0, 0);                 // R5 negative inf
    cyc(0, 0, 1, 6'h04, 0, 64'h1234, 0, 0);                 // R5 positive inf
    cyc(0, 0, 1, 6'h08, 0, 64'h5555, 0, 0);                 // R6
    cyc(0, 0, 1, 6'h08, 1, 64'h5555, 0, 0);                 // R6
    cyc(0, 0, 1, 6'h32, 1, 64'h0000_0000_0000_0003, 0, 0);  // R7
    cyc(0, 0, 1, 6'h00, 0, 64'h3FF0_0000_0000_0000, 0, 0);  // R7
    cyc(0, 0, 1, 6'h0D, 0, 64'h9, 0, 0);                    // R8 inv wins
    cyc(0, 0, 1, 6'h0C, 1, 64'h9, 0, 0);                    // R8 dz over ovf
    cyc(0, 0, 0, 6'h00, 0, 64'h0, 0, 1);                    // R12 clear
    cyc(0, 0, 1, 6'h10, 0, 64'h7, 0, 1);                    // R12 op with clear
    // R2: write unmasks dz; op in same cycle uses old mask
    cyc(1, 16'hAC3B, 1, 6'h04, 0, 64'h0, 0, 0);
    // R9 / R10: unmasked dz, issue in same cycle sees nothing yet
    cyc(0, 0, 1, 6'h04, 1, 64'h0, 1, 0);
    cyc(0, 0, 0, 6'h00, 0, 64'h0, 1, 0);                    // R10 trap
    cyc(0, 0, 0, 6'h00, 0, 64'h0, 0, 0);
    cyc(0, 0, 0, 6'h00, 0, 64'h0, 1, 0);                    // R10 still pending
    cyc(0, 0, 0, 6'h00, 0, 64'h0, 1, 1);                    // R12 clear with issue
    cyc(0, 0, 0, 6'h00, 0, 64'h0, 1, 0);                    // R12 trap gone
    cyc(1, 16'h0C3F, 0, 6'h00, 0, 64'h0, 0, 0);             // R2 remask
    cyc(0, 0, 1, 6'h04, 0, 64'h0, 1, 0);                    // R5 masked again
    cyc(0, 0, 0, 6'h00, 0, 64'h0, 1, 0);                    // R10 no trap

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] wd;
      wd = 16'($urandom);
      wd[5:0] = 6'($urandom) | 6'($urandom);
      cyc(($urandom % 8) == 0, wd, ($urandom % 10) < 7,
          6'($urandom) & 6'($urandom) & 6'($urandom), 1'($urandom),
          {$urandom, $urandom}, ($urandom % 4) == 0, ($urandom % 16) == 0);
    end
    cyc(0, 0, 0, 6'h00, 0, 64'h0, 0, 0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule